// File: doc/BRIEF.md
# Chip-Select Matcher with Online-Spare Redirect

This block takes a memory-controller input address that has already been normalized (node base removed, interleave bits excised) and decides which rank, identified by a chip-select number, responds to it. It holds a small programmable table of rank decoders. Each decoder has a base pattern, a don't-care mask and an enable bit. Software programs the table through a simple register-write port.

After the table lookup, a substitution stage applies the online-spare configuration. A retired rank number and a replacement rank number are held in the block. A lookup that lands on the retired rank is reported as the replacement rank. The replacement rank keeps its own decoder programming, and that programming plays no part in the redirect. A redirect that names a replacement outside the table is reported as an error instead of a hit.

Lookups are issued one per cycle with `lookup_valid`. The outcome appears on the result ports one clock later as exactly one of hit, miss or error.

Top module: `cs_remap_top`

## Requirements
- R1: After reset every table entry is disabled, the retired and replacement numbers both hold the invalid marker (all ones, 15 with the default widths), and `res_valid`, `res_hit`, `res_miss`, `res_err` and `res_redirected` are 0 with `res_cs` equal to the invalid marker.
- R2: Entry i matches address A when `(A & ~mask_i) == (base_i & ~mask_i)`, so a mask bit of 1 makes that address bit don't-care. On a hit without redirect, `res_cs` is the matching index.
- R3: An entry whose enable bit is 0 never matches, whatever its base and mask.
- R4: When several enabled entries match, the lowest index is reported.
- R5: When no enabled entry matches, `res_miss` is 1 and `res_cs` is the invalid marker.
- R6: No redirect takes place when the matched index differs from the retired number, which includes the case where both the retired and replacement numbers are the invalid marker. `res_redirected` is then 0.
- R7: When the matched index equals the retired number and the replacement number is below the table size, `res_hit` is 1, `res_redirected` is 1 and `res_cs` is the replacement number, whether or not the replacement entry is enabled or matches the address.
- R8: When the matched index equals the retired number and the replacement number is not below the table size (including the invalid marker), `res_err` is 1, `res_hit` is 0 and `res_cs` is the invalid marker.
- R9: A lookup presented in cycle n produces its result in cycle n+1 with `res_valid` 1 and exactly one of hit, miss or error set. In a cycle after no lookup, `res_valid` and all three outcome flags are 0.
- R10: A table write or spare-configuration write in the same cycle as a lookup affects lookups from the next cycle on, not the concurrent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr | input | 1 | Write one table entry |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_base | input | AW | Base pattern to write |
| tbl_mask | input | AW | Don't-care mask to write |
| tbl_en | input | 1 | Enable bit to write |
| spare_wr | input | 1 | Load retired and replacement numbers |
| retired_num | input | NUM_W | Retired rank number to load |
| replace_num | input | NUM_W | Replacement rank number to load |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_addr | input | AW | Normalized address to look up |
| res_valid | output | 1 | Result of last cycle's lookup is present |
| res_hit | output | 1 | Lookup resolved to a rank |
| res_miss | output | 1 | No enabled entry matched |
| res_err | output | 1 | Redirect requested to an out-of-range replacement |
| res_redirected | output | 1 | Hit was substituted by the replacement rank |
| res_cs | output | NUM_W | Resolved chip-select number, or the invalid marker |

## Verification
Overlapping decoders with different mask widths tell the masked compare apart from an exact compare and show that the lowest index wins when two entries both claim an address. A correctly programmed but disabled decoder, and its later enabling, distinguish the enable gate from the compare. Spare configurations are tried with the replacement entry disabled, with a replacement outside the table, with both numbers at the marker and with a lookup to a non-retired rank, separating redirect, error and pass-through. A write issued together with a lookup, and a stream of pseudo-random addresses around the programmed bases, confirm the one-cycle ordering against a behavioural model compared every clock.

// File: rtl/cs_remap_pkg.sv
package cs_remap_pkg;
    typedef enum logic [1:0] {
        OUT_NONE = 2'd0,
        OUT_HIT  = 2'd1,
        OUT_MISS = 2'd2,
        OUT_ERR  = 2'd3
    } outcome_e;
endpackage

// File: rtl/cs_entry_table.sv
module cs_entry_table #(
    parameter int NUM_CS = 8,
    parameter int AW     = 16,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [IDX_W-1:0]           idx_i,
    input  logic [AW-1:0]              base_i,
    input  logic [AW-1:0]              mask_i,
    input  logic                       en_i,
    output logic [NUM_CS-1:0][AW-1:0]  base_o,
    output logic [NUM_CS-1:0][AW-1:0]  mask_o,
    output logic [NUM_CS-1:0]          en_o
);
    typedef struct packed {
        logic [NUM_CS-1:0][AW-1:0] base;
        logic [NUM_CS-1:0][AW-1:0] mask;
        logic [NUM_CS-1:0]         en;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_i && (int'(idx_i) < NUM_CS)) begin
            tbl_d.base[idx_i] = base_i;
            tbl_d.mask[idx_i] = mask_i;
            tbl_d.en[idx_i]   = en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign base_o = tbl_q.base;
    assign mask_o = tbl_q.mask;
    assign en_o   = tbl_q.en;

    // R10: a written entry holds the written enable one cycle later
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> en_o[$past(idx_i)] == $past(en_i));
endmodule

// File: rtl/cs_match_scan.sv
module cs_match_scan #(
    parameter int NUM_CS = 8,
    parameter int AW     = 16,
    localparam int IDX_W = $clog2(NUM_CS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [AW-1:0]              addr_i,
    input  logic [NUM_CS-1:0][AW-1:0]  base_i,
    input  logic [NUM_CS-1:0][AW-1:0]  mask_i,
    input  logic [NUM_CS-1:0]          en_i,
    output logic                       hit_o,
    output logic [IDX_W-1:0]           idx_o
);
    logic [NUM_CS-1:0] cand;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        assign cand[g] = en_i[g] &&
                         ((addr_i & ~mask_i[g]) == (base_i[g] & ~mask_i[g]));
    end

    always_comb begin
        hit_o = |cand;
        idx_o = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (cand[i]) idx_o = IDX_W'(i);
        end
    end

    // R3: a reported entry is always an enabled one
    p_hit_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> en_i[idx_o]);
    // R2: the reported entry agrees with the address outside its mask
    p_hit_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((addr_i ^ base_i[idx_o]) & ~mask_i[idx_o]) == '0);
endmodule

// File: rtl/cs_spare_stage.sv
module cs_spare_stage
    import cs_remap_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int IDX_W = $clog2(NUM_CS),
    localparam int NUM_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [NUM_W-1:0] retired_i,
    input  logic [NUM_W-1:0] replace_i,
    output outcome_e         kind_o,
    output logic [NUM_W-1:0] cs_o,
    output logic             redir_o
);
    localparam logic [NUM_W-1:0] MARK = '1;

    logic [NUM_W-1:0] found;
    logic             spare_off;
    logic             on_retired;

    assign found      = {1'b0, idx_i};
    assign spare_off  = (retired_i == MARK) && (replace_i == MARK);
    assign on_retired = hit_i && !spare_off && (found == retired_i);

    always_comb begin
        kind_o  = OUT_MISS;
        cs_o    = MARK;
        redir_o = 1'b0;
        if (hit_i) begin
            if (!on_retired) begin
                kind_o = OUT_HIT;
                cs_o   = found;
            end else if (replace_i < NUM_W'(NUM_CS)) begin
                kind_o  = OUT_HIT;
                cs_o    = replace_i;
                redir_o = 1'b1;
            end else begin
                kind_o = OUT_ERR;
            end
        end
    end

    // R8: an error only arises from a lookup that landed on the retired rank
    p_err_from_retired_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == OUT_ERR) |-> (hit_i && retired_i == found));
    // R6: a substitution never happens for a rank other than the retired one
    p_redir_only_retired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (found == retired_i && kind_o == OUT_HIT));
endmodule

// File: rtl/cs_remap_top.sv
module cs_remap_top
    import cs_remap_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int AW     = 16,
    localparam int IDX_W = $clog2(NUM_CS),
    localparam int NUM_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [AW-1:0]    tbl_base,
    input  logic [AW-1:0]    tbl_mask,
    input  logic             tbl_en,
    input  logic             spare_wr,
    input  logic [NUM_W-1:0] retired_num,
    input  logic [NUM_W-1:0] replace_num,
    input  logic             lookup_valid,
    input  logic [AW-1:0]    lookup_addr,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_err,
    output logic             res_redirected,
    output logic [NUM_W-1:0] res_cs
);
    localparam logic [NUM_W-1:0] MARK = '1;

    typedef struct packed {
        logic [NUM_W-1:0] retired;
        logic [NUM_W-1:0] replace;
        logic             valid;
        logic             hit;
        logic             miss;
        logic             err;
        logic             redir;
        logic [NUM_W-1:0] cs;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CS-1:0][AW-1:0] ent_base;
    logic [NUM_CS-1:0][AW-1:0] ent_mask;
    logic [NUM_CS-1:0]         ent_en;
    logic                      scan_hit;
    logic [IDX_W-1:0]          scan_idx;
    outcome_e                  kind;
    logic [NUM_W-1:0]          sub_cs;
    logic                      sub_redir;

    cs_entry_table #(.NUM_CS(NUM_CS), .AW(AW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_i(tbl_wr), .idx_i(tbl_idx), .base_i(tbl_base),
        .mask_i(tbl_mask), .en_i(tbl_en),
        .base_o(ent_base), .mask_o(ent_mask), .en_o(ent_en)
    );

    cs_match_scan #(.NUM_CS(NUM_CS), .AW(AW)) u_scan (
        .clk(clk), .rst_n(rst_n), .addr_i(lookup_addr),
        .base_i(ent_base), .mask_i(ent_mask), .en_i(ent_en),
        .hit_o(scan_hit), .idx_o(scan_idx)
    );

    cs_spare_stage #(.NUM_CS(NUM_CS)) u_spare (
        .clk(clk), .rst_n(rst_n),
        .hit_i(scan_hit), .idx_i(scan_idx),
        .retired_i(st_q.retired), .replace_i(st_q.replace),
        .kind_o(kind), .cs_o(sub_cs), .redir_o(sub_redir)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = lookup_valid;
        st_d.hit   = lookup_valid && (kind == OUT_HIT);
        st_d.miss  = lookup_valid && (kind == OUT_MISS);
        st_d.err   = lookup_valid && (kind == OUT_ERR);
        st_d.redir = lookup_valid && sub_redir;
        st_d.cs    = lookup_valid ? sub_cs : MARK;
        if (spare_wr) begin
            st_d.retired = retired_num;
            st_d.replace = replace_num;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.retired <= MARK;
            st_q.replace <= MARK;
            st_q.cs      <= MARK;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid      = st_q.valid;
    assign res_hit        = st_q.hit;
    assign res_miss       = st_q.miss;
    assign res_err        = st_q.err;
    assign res_redirected = st_q.redir;
    assign res_cs         = st_q.cs;

    // R9: one-cycle result timing and a single outcome per result
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> res_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !res_valid && !res_hit && !res_miss && !res_err);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_err}) == 1);
    // R5 / R8: non-hit outcomes report the marker
    p_miss_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_miss || res_err) |-> res_cs == MARK);
    // R7: a substituted result carries the replacement in force at lookup time
    p_spare_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_redirected && $past(rst_n)) |-> res_cs == $past(st_q.replace));
    // R2: a hit always names a table index
    p_hit_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_cs < NUM_W'(NUM_CS));
endmodule

// File: tb/cs_remap_top_tb.sv
module cs_remap_top_tb;
    localparam int NUM_CS = 8;
    localparam int AW     = 16;
    localparam int MARK   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [15:0] tbl_base = '0;
    logic [15:0] tbl_mask = '0;
    logic        tbl_en = 1'b0;
    logic        spare_wr = 1'b0;
    logic [3:0]  retired_num = '0;
    logic [3:0]  replace_num = '0;
    logic        lookup_valid = 1'b0;
    logic [15:0] lookup_addr = '0;
    logic        res_valid, res_hit, res_miss, res_err, res_redirected;
    logic [3:0]  res_cs;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    int m_base[NUM_CS];
    int m_mask[NUM_CS];
    bit m_en[NUM_CS];
    int m_ret = MARK;
    int m_rep = MARK;

    always #5 clk = ~clk;

    cs_remap_top #(.NUM_CS(NUM_CS), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_base(tbl_base),
        .tbl_mask(tbl_mask), .tbl_en(tbl_en),
        .spare_wr(spare_wr), .retired_num(retired_num), .replace_num(replace_num),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_err(res_err), .res_redirected(res_redirected), .res_cs(res_cs)
    );

    // One clock: predict from the model state, update the model, compare after the edge.
    task automatic tick();
        bit e_v = 0, e_h = 0, e_m = 0, e_e = 0, e_r = 0;
        int e_cs = MARK;
        if (lookup_valid) begin
            int found = -1;
            e_v = 1;
            for (int i = 0; i < NUM_CS; i++) begin
                if (m_en[i] && (((int'(lookup_addr) ^ m_base[i]) & ~m_mask[i] & 16'hFFFF) == 0)) begin
                    found = i;
                    break;
                end
            end
            if (found < 0) e_m = 1;
            else if (!(m_ret == MARK && m_rep == MARK) && found == m_ret) begin
                if (m_rep < NUM_CS) begin e_h = 1; e_r = 1; e_cs = m_rep; end
                else e_e = 1;
            end else begin
                e_h = 1; e_cs = found;
            end
        end
        if (tbl_wr) begin
            m_base[tbl_idx] = tbl_base;
            m_mask[tbl_idx] = tbl_mask;
            m_en[tbl_idx]   = tbl_en;
        end
        if (spare_wr) begin
            m_ret = retired_num;
            m_rep = replace_num;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== e_v || res_hit !== e_h || res_miss !== e_m || res_err !== e_e ||
            res_redirected !== e_r || int'(res_cs) !== e_cs) begin
            errors++;
            $display("FAIL %s: got v%0b h%0b m%0b e%0b r%0b cs%0d, expected v%0b h%0b m%0b e%0b r%0b cs%0d",
                     tag, res_valid, res_hit, res_miss, res_err, res_redirected, res_cs,
                     e_v, e_h, e_m, e_e, e_r, e_cs);
        end
        tbl_wr = 0; spare_wr = 0; lookup_valid = 0;
    endtask

    task automatic wr_entry(input int idx, input int base, input int mask, input bit en);
        tbl_wr = 1; tbl_idx = 3'(idx); tbl_base = 16'(base); tbl_mask = 16'(mask); tbl_en = en;
        tick();
    endtask

    task automatic wr_spare(input int ret, input int rep);
        spare_wr = 1; retired_num = 4'(ret); replace_num = 4'(rep);
        tick();
    endtask

    task automatic look(input int addr);
        lookup_valid = 1; lookup_addr = 16'(addr);
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NUM_CS; i++) begin m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; tick();               // reset state, idle cycle
        tag = "R1"; look(16'h0000);        // empty table misses
        tag = "R2"; wr_entry(2, 16'h1200, 16'h00FF, 1);
        tag = "R2"; wr_entry(5, 16'h1200, 16'h0FFF, 1);
        tag = "R3"; wr_entry(3, 16'h4000, 16'h0000, 0);
        tag = "R4"; look(16'h1234);        // entries 2 and 5 both match, 2 wins
        tag = "R2"; look(16'h1A00);        // only the wider mask of 5 covers it
        tag = "R2"; look(16'h2200);        // outside both
        tag = "R3"; look(16'h4000);        // disabled exact match
        tag = "R3"; wr_entry(3, 16'h4000, 16'h0000, 1);
        tag = "R3"; look(16'h4000);
        tag = "R5"; look(16'h8000);
        tag = "R9"; tick();
        // same-cycle write and lookup: old contents used
        tag = "R10"; tbl_wr = 1; tbl_idx = 3'd1; tbl_base = 16'h8000; tbl_mask = 16'h0000; tbl_en = 1;
        lookup_valid = 1; lookup_addr = 16'h8000; tick();
        tag = "R10"; look(16'h8000);
        tag = "R7"; wr_spare(2, 6);         // entry 6 disabled and unprogrammed
        tag = "R7"; look(16'h1234);
        tag = "R6"; look(16'h1A00);
        tag = "R6"; look(16'h4000);
        // spare write concurrent with a lookup uses the old pair
        tag = "R10"; spare_wr = 1; retired_num = 4'd2; replace_num = 4'd9;
        lookup_valid = 1; lookup_addr = 16'h1234; tick();
        tag = "R8"; look(16'h1234);         // replacement 9 outside the table
        tag = "R8"; wr_spare(2, 15);
        tag = "R8"; look(16'h1250);
        tag = "R6"; wr_spare(15, 15);
        tag = "R6"; look(16'h1234);
        tag = "R7"; wr_spare(5, 0);
        tag = "R7"; look(16'h1A00);
        tag = "R4"; look(16'h12FF);
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tag = "R2";
            if (lfsr[0]) begin
                lookup_valid = 1;
                lookup_addr = (lfsr[1] ? 16'h1200 : (lfsr[2] ? 16'h4000 : 16'h8000)) ^ (lfsr & 16'h0C3F);
            end
            tick();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule